// File: doc/BRIEF.md
# Sample Rate Ratio Tracking Servo

This block follows the ratio between two sample-rate strobes that are asynchronous to each other and to the system clock. One strobe marks each arriving input sample. The other marks each output sample that must be produced. Each strobe passes through its own synchronizer and rising-edge detector. A free-running write counter advances on every input event. A position accumulator holds an integer sample index plus a 16-bit fraction, and it advances by the current ratio estimate on every output event.

The difference between the delayed write position and the accumulator is the phase error. A second-order digital loop uses this error in two ways. A proportional share corrects the position. An integral share refines the ratio estimate. Together they let the block follow drifting rates and absorb jitter.

On each output event the block updates two values. The integer part of the position is the FIFO read start address. The bit-inverted fraction is the offset into the dense coefficient array: a short filter delay gives a large offset. A settle-speed select chooses between a fast and a slow pair of loop shifts, and it may change at any time during operation. A lock flag reports that the error has stayed small for a run of output events.

Top module: `rate_ratio_servo`

## Requirements
- R1: Each strobe is sampled by a two-flop synchronizer, and a rising edge causes exactly one event. A strobe first sampled high at clock edge k is acted on at edge k+2, so the outputs change just after edge k+2 and not earlier.
- R2: The outputs change only on output events. `rd_addr_o` equals the integer part of the position, bits [AW+15:16], modulo 2^AW.
- R3: `coef_ofs_o` equals the bitwise inverse of the 16-bit position fraction, bits [15:0].
- R4: The write counter counts input events modulo 2^AW. The phase error is `((wr - DELAY) * 65536) - pos`, taken as a signed (AW+16)-bit value. It uses the values held before the edge at which the events are applied.
- R5: On an output event, `pos <= pos + ratio + (err >>> KP)` and `ratio <= ratio + (err >>> KI)`. Both use arithmetic shifts and wrap modulo 2^(AW+16).
- R6: The shift pair (KP, KI) is taken from `settle_fast_i` at the output event: 1 selects (4, 8) and 0 selects (6, 12). The select may change at any clock while running.
- R7: Reset sets:
  - pos to -DELAY*65536, giving `rd_addr_o` = 2^AW - DELAY (56) and `coef_ofs_o` = 16'hFFFF;
  - ratio to 65536;
  - the write counter to 0;
  - `locked_o` to 0.
- R8: An output event whose error lies within ±131072 extends a run of in-bound events. An out-of-bound event clears the run. `locked_o` is 1 exactly while the run has reached 64 events.
- R9: With steady strobe periods of 10 and 12 clocks, the loop locks under either shift setting, including after a rate step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_strobe_i | input | 1 | Input-rate strobe, asynchronous |
| out_strobe_i | input | 1 | Output-rate strobe, asynchronous |
| settle_fast_i | input | 1 | 1 selects fast loop gains, 0 selects slow gains |
| rd_addr_o | output | AW | FIFO read start address (integer part of position) |
| coef_ofs_o | output | 16 | Coefficient array offset (inverted fraction) |
| locked_o | output | 1 | Loop locked |

## Verification
Reaching lock and then losing it through the ports is the hard part. The loop must first settle from a wrong ratio estimate. Then a rate step or a gain switch must push the error out of bounds. The stimulus runs square-wave strobes at a 10:12 period ratio until lock. It then steps the input period while the slow gains are active. Finally it toggles the gain select every few thousand clocks while the output period jitters. A behavioural model follows the loop and the lock run through all of this.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int FRAC_W = 16;
  localparam int N_STROBE = 2;
  localparam int IDX_IN = 0;
  localparam int IDX_OUT = 1;
endpackage

// File: rtl/rrs_strobe_sync.sv
module rrs_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic event_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  // rising edge seen after the synchronizer stages
  assign event_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r1_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);
endmodule

// File: rtl/rrs_servo_core.sv
module rrs_servo_core
  import rrs_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DELAY      = 8,
  parameter int RATIO_INIT = 65536,
  parameter int KP_FAST    = 4,
  parameter int KI_FAST    = 8,
  parameter int KP_SLOW    = 6,
  parameter int KI_SLOW    = 12,
  localparam int PW        = AW + FRAC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_evt_i,
  input  logic                 out_evt_i,
  input  logic                 fast_i,
  output logic [PW-1:0]        pos_o,
  output logic signed [PW-1:0] err_o
);
  localparam logic [AW-1:0] DLY_A    = AW'(DELAY);
  localparam logic [AW-1:0] NEG_DLY  = -DLY_A;
  localparam logic [PW-1:0] POS_INIT = {NEG_DLY, {FRAC_W{1'b0}}};

  logic [AW-1:0]        wr_q;
  logic [PW-1:0]        pos_q, ratio_q;
  logic signed [PW-1:0] prop, integ;

  assign err_o = signed'({wr_q - DLY_A, {FRAC_W{1'b0}}} - pos_q);

  always_comb begin
    if (fast_i) begin
      prop  = err_o >>> KP_FAST;
      integ = err_o >>> KI_FAST;
    end else begin
      prop  = err_o >>> KP_SLOW;
      integ = err_o >>> KI_SLOW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      pos_q   <= POS_INIT;
      ratio_q <= PW'(RATIO_INIT);
    end else begin
      if (in_evt_i) wr_q <= wr_q + 1'b1;
      if (out_evt_i) begin
        pos_q   <= pos_q + ratio_q + prop;
        ratio_q <= ratio_q + integ;
      end
    end
  end

  assign pos_o = pos_q;

  a_r2_pos_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_evt_i |=> $stable(pos_q));
  a_r5_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_evt_i |=> $stable(ratio_q));
  a_r4_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_evt_i |=> wr_q == $past(wr_q) + 1'b1);
endmodule

// File: rtl/rrs_lock_detect.sv
module rrs_lock_detect #(
  parameter int PW  = 22,
  parameter int TOL = 131072,
  parameter int RUN = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 out_evt_i,
  input  logic signed [PW-1:0] err_i,
  output logic                 locked_o
);
  localparam int CW = $clog2(RUN + 1);
  localparam logic signed [PW-1:0] TOL_S = PW'(TOL);

  logic [CW-1:0] cnt_q;
  logic          in_bnd;

  assign in_bnd = (err_i <= TOL_S) && (err_i >= -TOL_S);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (out_evt_i) begin
      if (!in_bnd)                  cnt_q <= '0;
      else if (cnt_q != CW'(RUN))   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked_o = (cnt_q == CW'(RUN));

  a_r8_clear_on_excursion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_evt_i && !in_bnd) |=> !locked_o);
  a_r8_rise_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(out_evt_i));
endmodule

// File: rtl/rate_ratio_servo.sv
module rate_ratio_servo
  import rrs_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DELAY      = 8,
  parameter int RATIO_INIT = 65536,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_TOL   = 131072,
  parameter int LOCK_RUN   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_strobe_i,
  input  logic              out_strobe_i,
  input  logic              settle_fast_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic [FRAC_W-1:0] coef_ofs_o,
  output logic              locked_o
);
  localparam int PW = AW + FRAC_W;

  logic [N_STROBE-1:0]  strobe_raw, evt;
  logic [PW-1:0]        pos;
  logic signed [PW-1:0] err;

  assign strobe_raw[IDX_IN]  = in_strobe_i;
  assign strobe_raw[IDX_OUT] = out_strobe_i;

  for (genvar g = 0; g < N_STROBE; g++) begin : g_sync
    rrs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_raw[g]),
      .event_o  (evt[g])
    );
  end

  rrs_servo_core #(
    .AW(AW), .DELAY(DELAY), .RATIO_INIT(RATIO_INIT)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_evt_i  (evt[IDX_IN]),
    .out_evt_i (evt[IDX_OUT]),
    .fast_i    (settle_fast_i),
    .pos_o     (pos),
    .err_o     (err)
  );

  rrs_lock_detect #(.PW(PW), .TOL(LOCK_TOL), .RUN(LOCK_RUN)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .out_evt_i (evt[IDX_OUT]),
    .err_i     (err),
    .locked_o  (locked_o)
  );

  assign rd_addr_o  = pos[PW-1:FRAC_W];
  assign coef_ofs_o = ~pos[FRAC_W-1:0];

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt[IDX_OUT] |=> $stable(rd_addr_o) && $stable(coef_ofs_o));
endmodule

// File: tb/tb_rate_ratio_servo.sv
module tb_rate_ratio_servo;
  localparam int AW = 6;
  localparam longint PMASK = (64'd1 << (AW + 16)) - 1;
  localparam longint HALF  = 64'd1 << (AW + 15);
  localparam longint AMASK = (64'd1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic in_s = 0, out_s = 0, fast_s = 1;
  logic [AW-1:0] rd_addr;
  logic [15:0]   coef_ofs;
  logic          locked;

  always #2 clk = ~clk;

  rate_ratio_servo #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_strobe_i(in_s), .out_strobe_i(out_s),
    .settle_fast_i(fast_s), .rd_addr_o(rd_addr), .coef_ofs_o(coef_ofs),
    .locked_o(locked)
  );

  int vectors = 0, errors = 0, cyc = 0;
  bit cmp_en = 0;
  string phase = "R2";

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s act=%0h exp=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit     ih[$], oh[$];
  longint m_pos, m_ratio, m_err;
  int     m_wr, m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ih = '{0, 0, 0}; oh = '{0, 0, 0};
      m_pos = (-(64'd8 << 16)) & PMASK; m_ratio = 65536; m_wr = 0; m_run = 0;
    end else begin
      bit ie, oe;
      ie = ih[1] & ~ih[2];
      oe = oh[1] & ~oh[2];
      void'(ih.pop_back()); ih.push_front(in_s);
      void'(oh.pop_back()); oh.push_front(out_s);
      if (oe) begin
        int kp, ki;
        kp = fast_s ? 4 : 6; ki = fast_s ? 8 : 12;
        m_err = ((longint'((m_wr - 8) & AMASK) << 16) - m_pos) & PMASK;
        if (m_err >= HALF) m_err -= 2 * HALF;
        m_pos   = (m_pos + m_ratio + (m_err >>> kp)) & PMASK;
        m_ratio = (m_ratio + (m_err >>> ki)) & PMASK;
        if (m_err <= 131072 && m_err >= -131072) begin
          if (m_run < 64) m_run++;
        end else m_run = 0;
      end
      if (ie) m_wr = (m_wr + 1) & int'(AMASK);
    end
  end

  always @(negedge clk) if (cmp_en) begin
    chk("R2/R5 rd_addr", rd_addr, (m_pos >> 16) & AMASK);
    chk("R3 coef_ofs", coef_ofs, (~m_pos) & 16'hFFFF);
    chk("R8 locked", locked, (m_run == 64) ? 1 : 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  int in_per = 10, out_base = 12, out_per = 12, in_ph = 0, out_ph = 0;
  int lfsr = 16'hACE1, tog = 0;
  bit jit = 0;
  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      in_ph++;  if (in_ph >= in_per) in_ph = 0;
      out_ph++;
      if (out_ph >= out_per) begin
        out_ph = 0;
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
        out_per = jit ? out_base + (lfsr % 3) - 1 : out_base;
      end
      in_s  = in_ph < in_per / 2;
      out_s = out_ph < out_per / 2;
      if (tog != 0 && (cyc % tog) == 0) fast_s = ~fast_s;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    phase = "R7";
    chk("R7 reset rd_addr", rd_addr, 56);
    chk("R7 reset coef_ofs", coef_ofs, 16'hFFFF);
    chk("R7 reset locked", locked, 0);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    // directed single output edge, no inputs
    phase = "R1";
    out_s = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 no change before edge k+2", rd_addr, 56);
    @(negedge clk);
    chk("R1/R4 rd_addr after first event", rd_addr, 57);
    chk("R4 coef_ofs zero error", coef_ofs, 16'hFFFF);
    out_s = 0;
    repeat (6) @(negedge clk);
    // fast gains, steady 10:12
    phase = "R5"; fast_s = 1;
    run(30000);
    chk("R9 locked fast", locked, 1);
    // slow gains, rate step
    phase = "R6"; fast_s = 0; in_per = 9;
    run(45000);
    chk("R9 locked slow after step", locked, 1);
    // toggled gains with jitter
    phase = "R6"; jit = 1; tog = 2000;
    run(30000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule